// File: doc/BRIEF.md
# Load-Slice Instruction Steering with Dual In-Order Issue Queues

This block sits between decode and issue of a simple in-order core. It accepts one decoded instruction per cycle in program order and places it into one of two in-order queues: a main queue for ordinary work and a bypass queue for memory work. Loads always take the bypass queue. A store becomes two micro-operations: an address part on the bypass queue and a data part on the main queue. An arithmetic instruction takes the bypass queue only when a small learning table marks its instruction address as a producer of memory addresses. Because of this, address computation and loads can run ahead while the head of the main queue waits on a long-latency result.

The table learns from execution. A per-register record holds the instruction address of the latest writer of each register. When a load, a store, or an already-marked instruction is accepted, the writers of its address sources are entered into the table. Each further pass through the same code therefore extends the marked slice by one producer step.

Dispatch is a valid/ready interface. The instruction fields must stay stable while `disp_valid` is high and `disp_ready` is low. `disp_ready` depends on the fields presented in the same cycle. Each queue head is a separate valid/ready output, and a uop leaves when valid and ready are both high. A head is valid only when its enabled sources are not busy in a register scoreboard. A completion port clears busy bits. A flush empties both queues and the scoreboard but keeps everything learned.

Top module: `lsc_steer`

## Requirements
- R1: Each queue hands out its uops strictly in the order they were pushed. A uop leaves the head when `<q>_valid` and `<q>_ready` are both high. Uop layout: [51:20] pc, [19:18] kind (0 arithmetic, 1 load, 2 store address, 3 store data), [17:13] dst, [12] dst enable, [11:7] src1, [6] src1 enable, [5:1] src2, [0] src2 enable.
- R2: An accepted instruction with `disp_kind`=1 (load) goes only to the bypass queue as kind 1. All fields are copied, and the src2 enable is cleared.
- R3: An accepted store (`disp_kind`=2) pushes to both queues in the same cycle. The bypass queue gets kind 2 with dst and src2 enables cleared. The main queue gets kind 3 with dst and src1 enables cleared. All register fields are copied unchanged.
- R4: `disp_kind` 0 or 3 is arithmetic. It goes to the bypass queue as kind 0 when the table entry at pc[6:2] is valid and holds tag pc[31:7]. Otherwise it goes to the main queue as kind 0.
- R5: When a load, a store, or a table-hit arithmetic instruction is accepted, the pc of the latest accepted writer of each of its enabled address sources is entered into the table. Address sources are src1 for loads and stores, and src1 and src2 for a hit. The entry is visible from the next cycle. Writers are dst-enabled loads and arithmetic instructions. The writer record is read before the current instruction updates it. If two entries land on the same index, the src2 writer wins.
- R6: `disp_ready` is high exactly when flush is low and every queue the instruction needs held fewer than 8 entries at the start of the cycle. While it is low nothing is enqueued.
- R7: A head is valid exactly when its queue is non-empty, flush is low, and no enabled source is busy. A dst register becomes busy the cycle after its uop issues. It becomes free the cycle after `cmpl_valid` names it. If both happen in the same cycle, busy wins.
- R8: A flush leaves both queues empty and all registers free on the next cycle. During the flush cycle dispatch and both heads are held off. The learning table and writer record are kept.
- R9: After reset both queues are empty, no register is busy, and the table is empty, so the first arithmetic instruction at any pc goes to the main queue.
- R10: A store-address uop waiting on a busy source holds back every later bypass uop, including a load whose source is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty queues and scoreboard |
| disp_valid | input | 1 | Dispatch instruction present |
| disp_ready | output | 1 | Dispatch accepted this cycle if valid |
| disp_pc | input | 32 | Instruction address |
| disp_kind | input | 2 | 0/3 arithmetic, 1 load, 2 store |
| disp_dst | input | 5 | Destination register |
| disp_dst_en | input | 1 | Destination is written |
| disp_src1 | input | 5 | First source (address base for memory ops) |
| disp_src1_en | input | 1 | First source used |
| disp_src2 | input | 5 | Second source (store data) |
| disp_src2_en | input | 1 | Second source used |
| main_valid | output | 1 | Main head may issue |
| main_ready | input | 1 | Issue stage takes main head |
| main_uop | output | 52 | Main head uop |
| byp_valid | output | 1 | Bypass head may issue |
| byp_ready | input | 1 | Issue stage takes bypass head |
| byp_uop | output | 52 | Bypass head uop |
| cmpl_valid | input | 1 | A result has been written back |
| cmpl_reg | input | 5 | Register whose result completed |

## Verification
The bench replays a short loop of code several times and expects the slice to grow one producer per pass. A design that marked the whole chain at once, or never marked it, steers differently on the second and third passes. The bench fills the main queue until dispatch stalls while loads still have room, which exposes a ready signal that checks the wrong queue or lets a same-cycle pop make room. The bench also parks a store address on a busy register with a ready load behind it, and flushes with queues full and registers busy before replaying the learned loop. A design that let the load overtake, or that wiped the table on flush, diverges from the reference model. Mixed random traffic with pc values that alias in the table hits tag checks, same-cycle completion and issue on one register, and two marks landing on a single index.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  parameter int PC_W  = 32;
  parameter int REG_W = 5;
  parameter int NREG  = 1 << REG_W;

  localparam logic [1:0] DK_ALU   = 2'd0;
  localparam logic [1:0] DK_LOAD  = 2'd1;
  localparam logic [1:0] DK_STORE = 2'd2;

  typedef enum logic [1:0] {
    UK_ALU    = 2'd0,
    UK_LOAD   = 2'd1,
    UK_STADDR = 2'd2,
    UK_STDATA = 2'd3
  } uop_kind_e;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    uop_kind_e        kind;
    logic [REG_W-1:0] dst;
    logic             d_en;
    logic [REG_W-1:0] s1;
    logic             s1_en;
    logic [REG_W-1:0] s2;
    logic             s2_en;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);
endpackage

// File: rtl/lsc_uop_fifo.sv
module lsc_uop_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= step_ptr(wr_q);
      if (pop)  rd_q <= step_ptr(rd_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R8
endmodule

// File: rtl/lsc_scoreboard.sv
module lsc_scoreboard
  import lsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cmpl_v,
  input  logic [REG_W-1:0] cmpl_reg,
  input  logic             set0_en,
  input  logic [REG_W-1:0] set0_reg,
  input  logic             set1_en,
  input  logic [REG_W-1:0] set1_reg,
  input  uop_t             qa,
  input  uop_t             qb,
  output logic             qa_ok,
  output logic             qb_ok
);
  logic [NREG-1:0] busy_q, busy_nx;

  always_comb begin
    busy_nx = busy_q;
    if (cmpl_v)  busy_nx[cmpl_reg] = 1'b0;
    if (set0_en) busy_nx[set0_reg] = 1'b1;
    if (set1_en) busy_nx[set1_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_q <= '0;
    else if (flush) busy_q <= '0;
    else            busy_q <= busy_nx;
  end

  assign qa_ok = (!qa.s1_en || !busy_q[qa.s1]) && (!qa.s2_en || !busy_q[qa.s2]);
  assign qb_ok = (!qb.s1_en || !busy_q[qb.s1]) && (!qb.s2_en || !busy_q[qb.s2]);

  AST_CMPL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_v && !flush && !(set0_en && set0_reg == cmpl_reg)
     && !(set1_en && set1_reg == cmpl_reg)) |=> !busy_q[$past(cmpl_reg)]); // R7
  AST_ISSUE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set0_en && !flush) |=> busy_q[$past(set0_reg)]); // R7
endmodule

// File: rtl/lsc_slice_learn.sv
module lsc_slice_learn
  import lsc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [PC_W-3:0]  pcw,
  input  logic [1:0]       kind,
  input  logic [REG_W-1:0] dst,
  input  logic             d_en,
  input  logic [REG_W-1:0] s1,
  input  logic             s1_en,
  input  logic [REG_W-1:0] s2,
  input  logic             s2_en,
  output logic             hit
);
  localparam int PCW_W   = PC_W - 2;
  localparam int TAG_W   = PCW_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [PCW_W-1:0] wpc_q [NREG];
  logic [NREG-1:0]  wvld_q;

  logic             is_mem, is_alu, mark;
  logic             w0_en, w1_en;
  logic [PCW_W-1:0] w0_pc, w1_pc;
  logic [IDX_W-1:0] w0_idx, w1_idx;

  assign hit    = vld_q[pcw[IDX_W-1:0]] && (tag_q[pcw[IDX_W-1:0]] == pcw[PCW_W-1:IDX_W]);
  assign is_mem = (kind == DK_LOAD) || (kind == DK_STORE);
  assign is_alu = !is_mem;
  assign mark   = acc && (is_mem || hit);
  assign w0_en  = mark && s1_en && wvld_q[s1];
  assign w1_en  = acc && is_alu && hit && s2_en && wvld_q[s2];
  assign w0_pc  = wpc_q[s1];
  assign w1_pc  = wpc_q[s2];
  assign w0_idx = w0_pc[IDX_W-1:0];
  assign w1_idx = w1_pc[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wvld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
      for (int r = 0; r < NREG; r++)    wpc_q[r] <= '0;
    end else begin
      if (w0_en) begin
        vld_q[w0_idx] <= 1'b1;
        tag_q[w0_idx] <= w0_pc[PCW_W-1:IDX_W];
      end
      if (w1_en) begin
        vld_q[w1_idx] <= 1'b1;
        tag_q[w1_idx] <= w1_pc[PCW_W-1:IDX_W];
      end
      if (acc && d_en && kind != DK_STORE) begin
        wvld_q[dst] <= 1'b1;
        wpc_q[dst]  <= pcw;
      end
    end
  end

  AST_MARK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    w0_en |=> vld_q[$past(w0_idx)]); // R5
endmodule

// File: rtl/lsc_steer.sv
module lsc_steer
  import lsc_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int STAB_IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [PC_W-1:0]  disp_pc,
  input  logic [1:0]       disp_kind,
  input  logic [REG_W-1:0] disp_dst,
  input  logic             disp_dst_en,
  input  logic [REG_W-1:0] disp_src1,
  input  logic             disp_src1_en,
  input  logic [REG_W-1:0] disp_src2,
  input  logic             disp_src2_en,
  output logic             main_valid,
  input  logic             main_ready,
  output logic [UOP_W-1:0] main_uop,
  output logic             byp_valid,
  input  logic             byp_ready,
  output logic [UOP_W-1:0] byp_uop,
  input  logic             cmpl_valid,
  input  logic [REG_W-1:0] cmpl_reg
);
  logic hit, acc, is_load, is_store, need_m, need_b;
  logic m_push, b_push, m_pop, b_pop;
  logic m_empty, m_full, b_empty, b_full, m_ok, b_ok;
  uop_t base, m_in, b_in, m_head, b_head;

  assign is_load  = (disp_kind == DK_LOAD);
  assign is_store = (disp_kind == DK_STORE);
  assign need_b   = is_load || is_store || hit;
  assign need_m   = is_store || (!is_load && !hit);
  assign disp_ready = !flush && (!need_m || !m_full) && (!need_b || !b_full);
  assign acc      = disp_valid && disp_ready;
  assign m_push   = acc && need_m;
  assign b_push   = acc && need_b;

  always_comb begin
    base = '{pc: disp_pc, kind: UK_ALU, dst: disp_dst, d_en: disp_dst_en,
             s1: disp_src1, s1_en: disp_src1_en, s2: disp_src2, s2_en: disp_src2_en};
    m_in = base;
    b_in = base;
    if (is_store) begin
      m_in.kind  = UK_STDATA;
      m_in.d_en  = 1'b0;
      m_in.s1_en = 1'b0;
      b_in.kind  = UK_STADDR;
      b_in.d_en  = 1'b0;
      b_in.s2_en = 1'b0;
    end else if (is_load) begin
      b_in.kind  = UK_LOAD;
      b_in.s2_en = 1'b0;
    end
  end

  lsc_slice_learn #(.IDX_W(STAB_IDX_W)) u_learn (
    .clk(clk), .rst_n(rst_n), .acc(acc), .pcw(disp_pc[PC_W-1:2]),
    .kind(disp_kind), .dst(disp_dst), .d_en(disp_dst_en),
    .s1(disp_src1), .s1_en(disp_src1_en), .s2(disp_src2), .s2_en(disp_src2_en),
    .hit(hit)
  );

  lsc_uop_fifo #(.DEPTH(QDEPTH), .W(UOP_W)) u_mainq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(m_push), .din(m_in),
    .pop(m_pop), .dout(m_head), .empty(m_empty), .full(m_full)
  );

  lsc_uop_fifo #(.DEPTH(QDEPTH), .W(UOP_W)) u_bypq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(b_push), .din(b_in),
    .pop(b_pop), .dout(b_head), .empty(b_empty), .full(b_full)
  );

  lsc_scoreboard u_sb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cmpl_v(cmpl_valid), .cmpl_reg(cmpl_reg),
    .set0_en(m_pop && m_head.d_en), .set0_reg(m_head.dst),
    .set1_en(b_pop && b_head.d_en), .set1_reg(b_head.dst),
    .qa(m_head), .qb(b_head), .qa_ok(m_ok), .qb_ok(b_ok)
  );

  assign main_valid = !flush && !m_empty && m_ok;
  assign byp_valid  = !flush && !b_empty && b_ok;
  assign m_pop      = main_valid && main_ready;
  assign b_pop      = byp_valid && byp_ready;
  assign main_uop   = m_head;
  assign byp_uop    = b_head;

  AST_LOAD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_kind == DK_LOAD) |-> (b_push && !m_push)); // R2
  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_kind == DK_STORE) |-> (b_push && m_push)); // R3
  AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!m_push && !b_push && !m_pop && !b_pop)); // R8
endmodule

// File: tb/sim_lsc_steer.sv
module sim_lsc_steer;
  import lsc_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, flush = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [31:0] disp_pc = '0;
  logic [1:0] disp_kind = '0;
  logic [4:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic disp_dst_en = 1'b0, disp_src1_en = 1'b0, disp_src2_en = 1'b0;
  logic main_valid, main_ready = 1'b0, byp_valid, byp_ready = 1'b0;
  logic [UOP_W-1:0] main_uop, byp_uop;
  logic cmpl_valid = 1'b0;
  logic [4:0] cmpl_reg = '0;

  lsc_steer u0 (.*);

  uop_t mq[$], bq[$];
  bit mbusy[32], svld[32], wv[32];
  logic [24:0] stag[32];
  logic [31:0] wp[32];
  int pend[$];
  int checks = 0, fails = 0;
  string phase = "R9 reset";
  bit comp_allow = 1'b1, last_acc;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  function automatic bit src_ok(uop_t u);
    return (!u.s1_en || !mbusy[u.s1]) && (!u.s2_en || !mbusy[u.s2]);
  endfunction

  function automatic bit tbl_hit(logic [31:0] pc);
    return svld[pc[6:2]] && stag[pc[6:2]] == pc[31:7];
  endfunction

  task automatic mark(int r);
    if (wv[r]) begin
      svld[wp[r][6:2]] = 1'b1;
      stag[wp[r][6:2]] = wp[r][31:7];
    end
  endtask

  task automatic step();
    bit ev_m, ev_b, hit, ld, st, nm, nb, exp_dr;
    uop_t u, a;
    cmpl_valid = comp_allow && pend.size() > 0;
    cmpl_reg   = cmpl_valid ? 5'(pend[0]) : 5'd0;
    #1;
    ev_m = !flush && mq.size() > 0 && src_ok(mq[0]);
    ev_b = !flush && bq.size() > 0 && src_ok(bq[0]);
    hit = tbl_hit(disp_pc);
    ld = disp_kind == 2'd1;
    st = disp_kind == 2'd2;
    nb = ld || st || hit;
    nm = st || (!ld && !hit);
    exp_dr = !flush && (!nm || mq.size() < 8) && (!nb || bq.size() < 8);
    chk("disp_ready", 64'(disp_ready), 64'(exp_dr));
    chk("main_valid", 64'(main_valid), 64'(ev_m));
    chk("byp_valid", 64'(byp_valid), 64'(ev_b));
    if (ev_m && main_valid) chk("main_uop", 64'(main_uop), 64'(mq[0]));
    if (ev_b && byp_valid)  chk("byp_uop", 64'(byp_uop), 64'(bq[0]));
    last_acc = 1'b0;
    if (flush) begin
      mq.delete(); bq.delete(); pend.delete();
      foreach (mbusy[i]) mbusy[i] = 1'b0;
    end else begin
      if (cmpl_valid) begin
        mbusy[cmpl_reg] = 1'b0;
        void'(pend.pop_front());
      end
      if (ev_m && main_ready) begin
        u = mq.pop_front();
        if (u.d_en) begin mbusy[u.dst] = 1'b1; pend.push_back(int'(u.dst)); end
      end
      if (ev_b && byp_ready) begin
        u = bq.pop_front();
        if (u.d_en) begin mbusy[u.dst] = 1'b1; pend.push_back(int'(u.dst)); end
      end
      if (disp_valid && exp_dr) begin
        last_acc = 1'b1;
        u = '{pc: disp_pc, kind: UK_ALU, dst: disp_dst, d_en: disp_dst_en, s1: disp_src1,
              s1_en: disp_src1_en, s2: disp_src2, s2_en: disp_src2_en};
        if (ld) begin
          u.kind = UK_LOAD; u.s2_en = 1'b0; bq.push_back(u);
          if (disp_src1_en) mark(disp_src1);
        end else if (st) begin
          a = u; a.kind = UK_STADDR; a.d_en = 1'b0; a.s2_en = 1'b0;
          u.kind = UK_STDATA; u.d_en = 1'b0; u.s1_en = 1'b0;
          bq.push_back(a); mq.push_back(u);
          if (disp_src1_en) mark(disp_src1);
        end else if (hit) begin
          bq.push_back(u);
          if (disp_src1_en) mark(disp_src1);
          if (disp_src2_en) mark(disp_src2);
        end else mq.push_back(u);
        if (!st && disp_dst_en) begin wv[disp_dst] = 1'b1; wp[disp_dst] = disp_pc; end
      end
    end
    @(negedge clk);
  endtask

  task automatic set_insn(logic [31:0] pc, logic [1:0] k, int d, bit de, int s1, bit s1e, int s2, bit s2e);
    disp_pc = pc; disp_kind = k; disp_dst = 5'(d); disp_dst_en = de;
    disp_src1 = 5'(s1); disp_src1_en = s1e; disp_src2 = 5'(s2); disp_src2_en = s2e;
  endtask

  task automatic send(logic [31:0] pc, logic [1:0] k, int d, bit de, int s1, bit s1e, int s2, bit s2e);
    set_insn(pc, k, d, de, s1, s1e, s2, s2e);
    disp_valid = 1'b1;
    for (int n = 0; n < 60; n++) begin
      step();
      if (last_acc) break;
    end
    if (!last_acc) begin
      checks++; fails++;
      $display("FAIL %s: dispatch act=stalled exp=accepted", phase);
    end
    disp_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_loop();
    send(32'h100, 2'd0, 1, 1, 2, 1, 0, 0);
    send(32'h104, 2'd0, 3, 1, 1, 1, 4, 1);
    send(32'h108, 2'd1, 5, 1, 3, 1, 0, 0);
    send(32'h10C, 2'd0, 6, 1, 5, 1, 7, 1);
    idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: empty queues, ready dispatch, no valid heads
    idle(2);
    set_insn(32'h500, 2'd0, 2, 1, 0, 0, 0, 0);
    idle(1);

    phase = "R2 loads to bypass";
    send(32'h40, 2'd1, 5, 1, 1, 1, 9, 1);
    send(32'h44, 2'd1, 6, 1, 2, 1, 0, 0);
    idle(2);
    byp_ready = 1'b1; main_ready = 1'b1;
    idle(4);

    phase = "R3 store split";
    byp_ready = 1'b0; main_ready = 1'b0;
    send(32'h48, 2'd2, 11, 1, 3, 1, 4, 1);
    idle(2);
    main_ready = 1'b1; idle(1);
    byp_ready = 1'b1; idle(3);

    phase = "R5 slice learning";
    run_loop();
    run_loop();
    phase = "R4 table steering";
    run_loop();
    run_loop();

    phase = "R6 full stall";
    main_ready = 1'b0;
    for (int i = 0; i < 8; i++) send(32'h300 + 32'(4 * i), 2'd0, 12, 1, 13, 1, 0, 0);
    set_insn(32'h320, 2'd0, 12, 1, 0, 0, 0, 0);
    disp_valid = 1'b1;
    idle(3);
    disp_valid = 1'b0;
    set_insn(32'h324, 2'd1, 14, 1, 15, 1, 0, 0);
    idle(1);
    main_ready = 1'b1;
    send(32'h320, 2'd0, 12, 1, 0, 0, 0, 0);
    idle(12);

    phase = "R10 store address blocks loads";
    comp_allow = 1'b0;
    send(32'h400, 2'd0, 7, 1, 0, 0, 0, 0);
    idle(2);
    send(32'h404, 2'd2, 0, 0, 7, 1, 8, 1);
    send(32'h408, 2'd1, 9, 1, 10, 1, 0, 0);
    idle(4);
    comp_allow = 1'b1;
    idle(6);

    phase = "R8 flush keeps table";
    main_ready = 1'b1; byp_ready = 1'b1; comp_allow = 1'b0;
    send(32'h600, 2'd0, 16, 1, 0, 0, 0, 0);
    idle(2);
    main_ready = 1'b0; byp_ready = 1'b0;
    send(32'h604, 2'd0, 17, 1, 16, 1, 0, 0);
    send(32'h608, 2'd1, 18, 1, 16, 1, 0, 0);
    flush = 1'b1; idle(1); flush = 1'b0;
    comp_allow = 1'b1; main_ready = 1'b1; byp_ready = 1'b1;
    idle(2);
    run_loop();

    phase = "R1 R7 mixed traffic";
    for (int c = 0; c < 1500; c++) begin
      if (!disp_valid || last_acc) begin
        set_insn((($urandom % 4 == 0) ? 32'h280 : 32'h200) + 32'(4 * ($urandom % 8)),
                 2'($urandom % 4), int'($urandom % 8), ($urandom % 5) != 0,
                 int'($urandom % 8), $urandom % 2, int'($urandom % 8), $urandom % 2);
        disp_valid = ($urandom % 4) != 0;
      end
      main_ready = ($urandom % 3) != 0;
      byp_ready  = ($urandom % 3) != 0;
      comp_allow = ($urandom % 2) != 0;
      flush      = ($urandom % 97) == 0;
      step();
    end
    flush = 1'b0; disp_valid = 1'b0; comp_allow = 1'b1;
    idle(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule